// File: doc/BRIEF.md
# Split Code/Data Bank Selector

This block lets an 8-bit CPU with a 16-bit address bus reach two full 64K spaces, one that holds instructions and one that holds data. It watches the CPU's opcode-fetch marker, the read/write line and the data bus on every bus cycle. For each cycle it produces one bank-select bit, so that the memory decoder can steer that access to the code memory or to the data memory.

The opcode byte and its operand bytes come from the code space. The operand bytes are counted with a length decoder that is indexed by the fetched opcode. Every other access the instruction makes goes to the data space: plain reads, writes, and the read and write halves of read-modify-write operations. Selection counts read cycles, not cycles. A write placed between operand fetches, such as a return-address push during a subroutine call, still goes to data space, and the remaining operand reads stay in code space.

The select is registered. A bus cycle presented while the cycle-valid strobe is high is classified at the rising edge of the clock, and the result appears on `bank_sel` after that edge. A debug output shows the length given to the most recent opcode.

Top module: `bank_steer`

## Requirements
- R1: After reset, `bank_sel` is 0 (code space) and `dbg_len` is 0. Until the first valid cycle with `sync`=1, every valid cycle, read or write, selects code (`bank_sel`=0).
- R2: A valid cycle with `sync`=1 sets `bank_sel`=0 and sets `dbg_len` to the table length of the byte on `bus_d` after that clock edge. This holds whatever state the block was in before.
- R3: The length table gives 3 for these opcodes and 2 for all others, including undefined opcodes:
  - 0x20;
  - every opcode with low nibble 0xD;
  - every opcode with low nibble 0xE except 0x9E;
  - every opcode with low nibble 0x9 and bit 4 set;
  - 0x2C, 0x4C, 0x6C, 0x8C, 0xAC, 0xBC, 0xCC and 0xEC.
- R4: After a SYNC cycle with length L, the next L-1 valid read cycles (`rw`=1) select code (`bank_sel`=0).
- R5: Once those operand reads are used up, every valid read without `sync` selects data (`bank_sel`=1).
- R6: After the first SYNC, every valid write (`rw`=0) without `sync` selects data. A write does not use up an operand read, so a pending operand read that follows it still selects code.
- R7: A cycle with `cyc_vld`=0 changes neither `bank_sel`, nor `dbg_len`, nor the number of pending operand reads.
- R8: A SYNC cycle that arrives while operand reads are still pending discards them and starts counting afresh from the new opcode's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; cycles are classified at its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_vld | input | 1 | High when the bus signals describe a real bus cycle |
| sync | input | 1 | Opcode-fetch marker from the CPU |
| rw | input | 1 | 1 = read, 0 = write |
| bus_d | input | 8 | CPU data bus (opcode byte during a SYNC cycle) |
| bank_sel | output | 1 | Registered select: 0 = code space, 1 = data space |
| dbg_len | output | 2 | Length assigned to the last opcode (0 before the first) |

## Verification
Two things can meet in one cycle: a new SYNC and a pending operand read, and a write and a pending operand read. Directed sequences provoke both. A SYNC lands while an operand count is still pending, and a write falls between the operand reads of a three-byte opcode; the bench then checks that the new count wins and that the write leaves the count untouched. Constrained random traffic mixes idle, SYNC, read and write cycles at high density, so these collisions recur many times. Every cycle's select and length are judged against a bench model built from the requirements.

// File: rtl/bank_steer_pkg.sv
package bank_steer_pkg;

    // Encoding of the bank-select output.
    typedef enum logic {
        BANK_CODE = 1'b0,
        BANK_DATA = 1'b1
    } bank_e;

endpackage

// File: rtl/bsel_len_dec.sv
// Opcode length decoder: 3 for the absolute-address forms and the subroutine
// call, 2 for everything else, including undefined opcodes.
module bsel_len_dec #(
    parameter int OPC_W = 8,
    parameter int LEN_W = 2
) (
    input  logic [OPC_W-1:0] opc,
    output logic [LEN_W-1:0] len
);
    localparam int NIB_W = OPC_W / 2;

    logic [NIB_W-1:0] lo_nib;
    logic [NIB_W-1:0] hi_nib;
    logic             col_c_abs;
    logic             is_long;

    assign lo_nib = opc[NIB_W-1:0];
    assign hi_nib = opc[OPC_W-1:NIB_W];

    always_comb begin
        // Column C: even rows other than row 0, plus the indexed load at 0xBC.
        col_c_abs = (!hi_nib[0] && (hi_nib != '0)) || (opc == OPC_W'(8'hBC));
        is_long   = 1'b0;
        unique case (lo_nib)
            NIB_W'(4'hD): is_long = 1'b1;
            NIB_W'(4'hE): is_long = (opc != OPC_W'(8'h9E));
            NIB_W'(4'h9): is_long = hi_nib[0];
            NIB_W'(4'hC): is_long = col_c_abs;
            NIB_W'(4'h0): is_long = (opc == OPC_W'(8'h20));
            default:      is_long = 1'b0;
        endcase
        len = is_long ? LEN_W'(3) : LEN_W'(2);
    end

endmodule

// File: rtl/bsel_seq.sv
// Read-counting sequencer: picks the bank for each valid bus cycle.
module bsel_seq
    import bank_steer_pkg::*;
#(
    parameter int LEN_W = 2,
    parameter int CNT_W = 2,
    parameter int MAX_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_vld,
    input  logic             sync,
    input  logic             rw,
    input  logic [LEN_W-1:0] op_len,
    output bank_e            bank_q,
    output logic [LEN_W-1:0] len_q,
    output logic [CNT_W-1:0] pend_q
);
    typedef struct packed {
        logic             boot;
        bank_e            bank;
        logic [LEN_W-1:0] len;
        logic [CNT_W-1:0] pend;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cyc_vld) begin
            if (sync) begin
                st_d.boot = 1'b0;
                st_d.bank = BANK_CODE;
                st_d.len  = op_len;
                st_d.pend = CNT_W'(op_len - LEN_W'(1));
            end else if (st_q.boot) begin
                st_d.bank = BANK_CODE;
            end else if (rw && (st_q.pend != '0)) begin
                st_d.bank = BANK_CODE;
                st_d.pend = st_q.pend - CNT_W'(1);
            end else begin
                st_d.bank = BANK_DATA;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{boot: 1'b1, bank: BANK_CODE, len: '0, pend: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_q = st_q.bank;
    assign len_q  = st_q.len;
    assign pend_q = st_q.pend;

    // R2
    sync_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_vld && sync |=> (bank_q == BANK_CODE) && !st_q.boot);

    // R6
    wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_vld && !sync && !rw && !st_q.boot |=> bank_q == BANK_DATA);

    // R6
    wr_keep_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_vld && !sync && !rw |=> $stable(pend_q));

    // R5
    rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_vld && !sync && rw && !st_q.boot && (pend_q == '0) |=> bank_q == BANK_DATA);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_vld |=> $stable(bank_q) && $stable(len_q) && $stable(pend_q));

    // R4
    always_comb begin
        if (rst_n) begin
            pend_bound_chk: assert (int'(pend_q) < MAX_LEN);
        end
    end

endmodule

// File: rtl/bank_steer.sv
// Top: steers opcode and operand fetches to code space, the rest to data space.
module bank_steer #(
    parameter int DATA_W = 8,
    parameter int LEN_W = 2,
    parameter int MAX_LEN = 3,
    localparam int CNT_W = $clog2(MAX_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_vld,
    input  logic              sync,
    input  logic              rw,
    input  logic [DATA_W-1:0] bus_d,
    output logic              bank_sel,
    output logic [LEN_W-1:0]  dbg_len
);
    import bank_steer_pkg::*;

    logic [LEN_W-1:0] op_len;
    bank_e            bank_q;
    logic [CNT_W-1:0] pend_q;

    bsel_len_dec #(
        .OPC_W (DATA_W),
        .LEN_W (LEN_W)
    ) u_len (
        .opc (bus_d),
        .len (op_len)
    );

    bsel_seq #(
        .LEN_W   (LEN_W),
        .CNT_W   (CNT_W),
        .MAX_LEN (MAX_LEN)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_vld (cyc_vld),
        .sync    (sync),
        .rw      (rw),
        .op_len  (op_len),
        .bank_q  (bank_q),
        .len_q   (dbg_len),
        .pend_q  (pend_q)
    );

    assign bank_sel = bank_q;

    // R8
    resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_vld && sync |=> int'(pend_q) == int'(dbg_len) - 1);

endmodule

// File: tb/tb_bank_steer.sv
module tb_bank_steer;
    localparam int CLK_PERIOD = 10;
    localparam int SEED = 32'h5EED_0B17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_vld = 1'b0;
    logic       sync = 1'b0;
    logic       rw = 1'b1;
    logic [7:0] bus_d = '0;
    logic       bank_sel;
    logic [1:0] dbg_len;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model state
    bit m_boot;
    bit m_bank;
    int m_len;
    int m_pend;

    bank_steer dut (
        .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .sync(sync),
        .rw(rw), .bus_d(bus_d), .bank_sel(bank_sel), .dbg_len(dbg_len)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R3 reference table
    function automatic int ref_len(logic [7:0] op);
        if (op == 8'h20) return 3;
        if (op[3:0] == 4'hD) return 3;
        if (op[3:0] == 4'hE) return (op == 8'h9E) ? 2 : 3;
        if (op[3:0] == 4'h9) return op[4] ? 3 : 2;
        if (op == 8'h2C || op == 8'h4C || op == 8'h6C || op == 8'h8C ||
            op == 8'hAC || op == 8'hBC || op == 8'hCC || op == 8'hEC) return 3;
        return 2;
    endfunction

    // Returns the requirement a cycle exercises and advances the model.
    function automatic string model_step(bit v, bit s, bit r, logic [7:0] d);
        if (!v) return "R7";
        if (s) begin
            string t;
            t = (m_pend != 0) ? "R8" : "R2";
            m_boot = 0; m_bank = 0; m_len = ref_len(d); m_pend = m_len - 1;
            return t;
        end
        if (m_boot) begin m_bank = 0; return "R1"; end
        if (!r) begin m_bank = 1; return "R6"; end
        if (m_pend != 0) begin m_bank = 0; m_pend--; return "R4"; end
        m_bank = 1;
        return "R5";
    endfunction

    task automatic check(string tag, int act_b, int exp_b, int act_l, int exp_l);
        checks++;
        if (act_b != exp_b || act_l != exp_l) begin
            errors++;
            $display("FAIL %s: bank_sel=%0d dbg_len=%0d, expected bank_sel=%0d dbg_len=%0d",
                     tag, act_b, act_l, exp_b, exp_l);
        end
    endtask

    // Called at a falling edge: drive, let the rising edge pass, check at next falling edge.
    task automatic step(bit v, bit s, bit r, logic [7:0] d);
        string tag;
        cyc_vld = v; sync = s; rw = r; bus_d = d;
        tag = model_step(v, s, r, d);
        @(negedge clk);
        check(tag, int'(bank_sel), int'(m_bank), int'(dbg_len), m_len);
    endtask

    task automatic do_reset();
        rst_n = 0; cyc_vld = 0; sync = 0; rw = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_boot = 1; m_bank = 0; m_len = 0; m_pend = 0;
        check("R1", int'(bank_sel), 0, int'(dbg_len), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(SEED);
        @(negedge clk);
        do_reset();

        // R1: before the first SYNC, reads and writes stay in code space
        step(1, 0, 1, 8'hFC);
        step(1, 0, 0, 8'h00);
        step(1, 0, 1, 8'hFD);

        // R3: every opcode, with the length checked through dbg_len
        for (int op = 0; op < 256; op++) step(1, 1, 1, 8'(op));

        // R4/R6: subroutine call, push between operand reads
        step(1, 1, 1, 8'h20);  // R2 length 3
        step(1, 0, 1, 8'h34);  // R4 first operand
        step(1, 0, 0, 8'h12);  // R6 write, count kept
        step(1, 0, 0, 8'h12);  // R6
        step(1, 0, 1, 8'h56);  // R4 second operand still code
        step(1, 0, 1, 8'h00);  // R5 data read
        step(1, 0, 0, 8'h00);  // R6

        // R7: idle cycles hold everything, including a pending operand
        step(1, 1, 1, 8'hAD);  // length 3
        step(0, 1, 0, 8'h00);  // R7 ignored, even with sync high
        step(0, 0, 1, 8'h00);  // R7
        step(1, 0, 1, 8'h00);  // R4
        step(1, 0, 1, 8'h00);  // R4
        step(1, 0, 1, 8'h00);  // R5

        // R8: SYNC mid-operand restarts the count
        step(1, 1, 1, 8'hEE);  // length 3
        step(1, 1, 1, 8'hA9);  // R8 length 2
        step(1, 0, 1, 8'h00);  // R4
        step(1, 0, 1, 8'h00);  // R5
        step(1, 1, 1, 8'h9E);  // undefined-ish, length 2
        step(1, 0, 0, 8'h00);  // R6
        step(1, 0, 1, 8'h00);  // R4
        step(1, 0, 1, 8'h00);  // R5

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit v, s, r;
            v = ($urandom_range(99) < 85);
            s = ($urandom_range(99) < 25);
            r = s ? 1'b1 : ($urandom_range(99) < 70);
            step(v, s, r, 8'($urandom_range(255)));
        end

        // R1 again after a mid-run reset
        do_reset();
        step(1, 0, 0, 8'h00);
        step(1, 0, 1, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule